// File: doc/BRIEF.md
# Burst-Tolerant Manchester Decoder

This block turns a bi-phase-level (Manchester) serial line into a decoded data bit stream and a recovered bit clock. It is clocked by a sampling clock that runs at a fixed multiple of the nominal baud rate (16 by default). No phase-locked loop is used. Each accepted mid-cell transition starts a timing window of three quarters of a nominal cell. Transitions inside that window are cell-boundary transitions and are not decoded. Because of this, the block locks on the first transition of a burst and needs no preamble.

The recovered clock falls a fixed number of sampling clocks after every decoded mid-cell transition. How it rises depends on the next bit:

- When the next bit equals the current one, the line has a boundary transition. The clock rises on that transition, delayed by the same fixed amount, so the clock low time follows the line.
- When the next bit is the complement, there is no boundary transition. The clock is then held low for exactly half a nominal cell.

The data output carries the complement of each decoded bit. It changes one sampling clock after a falling edge of the recovered clock. Consumers therefore sample it on the rising edge of the recovered clock.

When the line stays quiet for two nominal cells, the valid flag drops. The window logic then returns to its unlocked state, so the next burst locks again. The first transition after an idle period, or after reset, is always taken as a mid-cell transition. The transmitter therefore starts each burst with the bit whose first half-cell equals the idle line level.

Top module: `mdec_top`

## Requirements
- R1: A falling mid-cell transition decodes as bit 1 and a rising one as bit 0. `data_n_o` presents the complement of the decoded bit, so it is 0 for a decoded 1.
- R2: The first transition after reset or after an idle timeout is decoded as a mid-cell transition. That bit is valid before the first rising edge of `rclk_o` in the burst, with no preamble.
- R3: A transition fewer than WIN = round(3·OVS/4) sampling clocks (12 by default) after an accepted one is ignored. Exactly one rising edge of `rclk_o` occurs per transmitted bit.
- R4: When no boundary transition falls inside the window, `rclk_o` stays low for exactly HALF = round(OVS/2) sampling clocks (8 by default).
- R5: When a boundary transition falls inside the window, `rclk_o` rises on it after the same fixed delay as the falling edge. Its low time therefore equals, in sampling clocks, the interval from the mid-cell transition to the boundary transition.
- R6: `data_n_o` changes only in the sampling clock right after a falling edge of `rclk_o`, and never while `rclk_o` is high.
- R7: Decoding stays correct for baud rates within ±15% of nominal and for first-half-cell duty cycles from 42.5% to 57.5%.
- R8: After 2·OVS sampling clocks with no line transition, `valid_o` clears and `rclk_o` is high. The next transition relocks as in R2.
- R9: While reset is held, and until the first transition, `rclk_o` = 1, `data_n_o` = 0 and `valid_o` = 0. The line is expected low at reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Sampling clock, OVS times the nominal baud rate |
| rst_ni | input | 1 | Active-low asynchronous reset |
| line_i | input | 1 | Raw Manchester serial line, asynchronous |
| rclk_o | output | 1 | Recovered bit clock |
| data_n_o | output | 1 | Complement of the decoded bit, valid at the rising edge of `rclk_o` |
| valid_o | output | 1 | High while locked on a burst and the output bit is meaningful |

## Verification
The hardest condition to reach is an equal-bit boundary transition arriving late in the window. This happens at the slowest allowed baud rate combined with the shortest first half-cell, where the boundary lands only one or two samples before the window closes. The bench gets there with a behavioural encoder that places each line transition at a real-valued time computed from the scaled cell length and the duty cycle. It then quantises that time to the sampling clock. Every recovered-clock low period is compared with the interval the encoder recorded between its own mid and boundary transitions, so both the window edge and the mode choice are checked bit by bit.

// File: rtl/mdec_pkg.sv
package mdec_pkg;

  typedef struct packed {
    logic mid;    // accepted mid-cell transition
    logic fall;   // direction of that transition (1 = falling)
    logic bnd;    // boundary transition inside the window
    logic nobnd;  // window closed with no boundary seen
    logic idle;   // quiet-line timeout
  } mdec_evt_t;

  function automatic int round_div(int n, int d);
    return (n + d / 2) / d;
  endfunction

endpackage

// File: rtl/mdec_sync.sv
module mdec_sync #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic line_i,
  output logic edge_o,
  output logic fall_o
);
  logic [SYNC_STAGES:0] sh_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sh_q <= '0;
    else         sh_q <= {sh_q[SYNC_STAGES-1:0], line_i};
  end

  // sh_q[SYNC_STAGES-1] is the synchronized level, sh_q[SYNC_STAGES] its previous value
  assign edge_o = sh_q[SYNC_STAGES-1] ^ sh_q[SYNC_STAGES];
  assign fall_o = sh_q[SYNC_STAGES] & ~sh_q[SYNC_STAGES-1];
endmodule

// File: rtl/mdec_delay.sv
module mdec_delay #(
  parameter int W     = 1,
  parameter int DEPTH = 1
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  if (DEPTH == 0) begin : g_wire
    assign q_o = d_i;
  end else begin : g_pipe
    logic [W-1:0] stg_q [DEPTH];
    for (genvar i = 0; i < DEPTH; i++) begin : g_stg
      if (i == 0) begin : g_first
        always_ff @(posedge clk_i or negedge rst_ni) begin
          if (!rst_ni) stg_q[i] <= '0;
          else         stg_q[i] <= d_i;
        end
      end else begin : g_next
        always_ff @(posedge clk_i or negedge rst_ni) begin
          if (!rst_ni) stg_q[i] <= '0;
          else         stg_q[i] <= stg_q[i-1];
        end
      end
    end
    assign q_o = stg_q[DEPTH-1];
  end
endmodule

// File: rtl/mdec_window.sv
module mdec_window
  import mdec_pkg::*;
#(
  parameter int OVS = 16
) (
  input  logic      clk_i,
  input  logic      rst_ni,
  input  logic      edge_i,
  input  logic      fall_i,
  output mdec_evt_t evt_o
);
  localparam int WIN  = round_div(3 * OVS, 4);
  localparam int IDLE = 2 * OVS;
  localparam int CW   = $clog2(IDLE + 1);

  logic [CW-1:0] win_cnt_q, quiet_cnt_q;
  logic          locked_q, bnd_seen_q;
  logic          open_w, acc, ign, close_now, timeout;

  assign open_w    = !locked_q || (win_cnt_q >= CW'(WIN));
  assign acc       = edge_i && open_w;
  assign ign       = edge_i && !open_w;
  assign close_now = locked_q && (win_cnt_q == CW'(WIN - 1));
  assign timeout   = locked_q && !edge_i && (quiet_cnt_q == CW'(IDLE - 1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      win_cnt_q   <= CW'(WIN);
      quiet_cnt_q <= '0;
      locked_q    <= 1'b0;
      bnd_seen_q  <= 1'b0;
      evt_o       <= '0;
    end else begin
      evt_o.mid   <= acc;
      evt_o.fall  <= acc & fall_i;
      evt_o.bnd   <= ign;
      evt_o.nobnd <= close_now && !bnd_seen_q && !ign;
      evt_o.idle  <= timeout;

      if (acc)                         win_cnt_q <= CW'(1);
      else if (win_cnt_q < CW'(WIN))   win_cnt_q <= win_cnt_q + 1'b1;

      if (edge_i)                      quiet_cnt_q <= '0;
      else if (quiet_cnt_q < CW'(IDLE)) quiet_cnt_q <= quiet_cnt_q + 1'b1;

      if (timeout)  locked_q <= 1'b0;
      else if (acc) locked_q <= 1'b1;

      if (acc)      bnd_seen_q <= 1'b0;
      else if (ign) bnd_seen_q <= 1'b1;
    end
  end
endmodule

// File: rtl/mdec_clkgen.sv
module mdec_clkgen (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic fall_ev_i,   // delayed mid-cell transition
  input  logic rise_pt_i,   // delayed boundary transition
  input  logic rise_tmr_i,  // window closed without boundary
  output logic rclk_o,
  output logic tmr_rise_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rclk_o     <= 1'b1;
      tmr_rise_o <= 1'b0;
    end else begin
      tmr_rise_o <= 1'b0;
      if (fall_ev_i) begin
        rclk_o <= 1'b0;
      end else if (rise_tmr_i && !rclk_o) begin
        rclk_o     <= 1'b1;
        tmr_rise_o <= 1'b1;
      end else if (rise_pt_i) begin
        rclk_o <= 1'b1;
      end
    end
  end
endmodule

// File: rtl/mdec_top.sv
module mdec_top
  import mdec_pkg::*;
#(
  parameter int OVS         = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic line_i,
  output logic rclk_o,
  output logic data_n_o,
  output logic valid_o
);
  localparam int WIN  = round_div(3 * OVS, 4);
  localparam int HALF = round_div(OVS, 2);
  // delay of the falling path so the no-boundary rise lands HALF later
  localparam int DLY  = WIN - 1 - HALF;

  logic      edge_s, fall_s;
  mdec_evt_t evt;
  logic [2:0] dly_in, dly_out;
  logic      mid_d, fall_d, bnd_d;
  logic      tmr_rise;
  logic      mid_q, bit_q;

  mdec_sync #(.SYNC_STAGES(SYNC_STAGES)) i_sync (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .line_i (line_i),
    .edge_o (edge_s),
    .fall_o (fall_s)
  );

  mdec_window #(.OVS(OVS)) i_window (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .edge_i (edge_s),
    .fall_i (fall_s),
    .evt_o  (evt)
  );

  assign dly_in = {evt.mid, evt.fall, evt.bnd};

  mdec_delay #(.W(3), .DEPTH(DLY)) i_delay (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .d_i    (dly_in),
    .q_o    (dly_out)
  );

  assign {mid_d, fall_d, bnd_d} = dly_out;

  mdec_clkgen i_clkgen (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .fall_ev_i  (mid_d),
    .rise_pt_i  (bnd_d),
    .rise_tmr_i (evt.nobnd),
    .rclk_o     (rclk_o),
    .tmr_rise_o (tmr_rise)
  );

  // data moves one cycle after the clock falls
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mid_q    <= 1'b0;
      bit_q    <= 1'b0;
      data_n_o <= 1'b0;
      valid_o  <= 1'b0;
    end else begin
      mid_q <= mid_d;
      bit_q <= fall_d;
      if (mid_q) data_n_o <= ~bit_q;
      if (evt.idle)   valid_o <= 1'b0;
      else if (mid_q) valid_o <= 1'b1;
    end
  end
endmodule

// File: rtl/mdec_chk.sv
module mdec_chk
  import mdec_pkg::*;
#(
  parameter int OVS = 16
) (
  input logic clk_i,
  input logic rst_ni,
  input logic line_i,
  input logic rclk_o,
  input logic data_n_o,
  input logic valid_o,
  input logic mid_i,
  input logic idle_i,
  input logic tmr_rise_i
);
  localparam int WIN  = round_div(3 * OVS, 4);
  localparam int HALF = round_div(OVS, 2);
  localparam int IDLE = 2 * OVS;
  localparam int CW   = $clog2(IDLE + 16) + 1;

  logic [CW-1:0] low_len, gap, qc;
  logic          armed, line_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      low_len <= '0;
      gap     <= '0;
      qc      <= '0;
      armed   <= 1'b0;
      line_q  <= 1'b0;
    end else begin
      if (rclk_o) low_len <= '0;
      else if (low_len < CW'(IDLE + 8)) low_len <= low_len + 1'b1;

      if (mid_i) gap <= CW'(1);
      else if (gap < CW'(IDLE + 8)) gap <= gap + 1'b1;

      if (idle_i)     armed <= 1'b0;
      else if (mid_i) armed <= 1'b1;

      line_q <= line_i;
      if (line_i != line_q) qc <= '0;
      else if (qc < CW'(IDLE + 12)) qc <= qc + 1'b1;
    end
  end

  a_r6_data_after_fall: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(data_n_o) |-> ($past(rclk_o, 2) && !$past(rclk_o)));

  a_r6_hold_while_high: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rclk_o && $past(rclk_o)) |-> $stable(data_n_o));

  a_r4_half_low: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tmr_rise_i |-> (low_len == CW'(HALF)));

  a_r3_window_gap: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mid_i && armed) |-> (gap >= CW'(WIN)));

  a_r8_idle_drop: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (qc > CW'(IDLE + 6)) |-> !valid_o);

  a_r8_clk_high_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(valid_o) |-> rclk_o);

endmodule

bind mdec_top mdec_chk #(.OVS(OVS)) i_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .line_i     (line_i),
  .rclk_o     (rclk_o),
  .data_n_o   (data_n_o),
  .valid_o    (valid_o),
  .mid_i      (evt.mid),
  .idle_i     (evt.idle),
  .tmr_rise_i (tmr_rise)
);

// File: tb/test_mdec_top.sv
`timescale 1ns/1ps
module test_mdec_top;
  localparam int OVS  = 16;
  localparam int HALF = 8;
  localparam int IDLE = 32;

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic line = 1'b0;
  logic rclk, data_n, valid;

  int n_cmp = 0;
  int n_bad = 0;
  int cyc = 0;
  bit done = 0;

  logic exp_bits [0:255];
  int   mid_n    [0:255];
  int   bnd_n    [0:255];
  int   burst_len = 0;
  int   exp_idx = 0;

  always #5 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  mdec_top #(.OVS(OVS)) i_mdec_top (
    .clk_i    (clk),
    .rst_ni   (rst_ni),
    .line_i   (line),
    .rclk_o   (rclk),
    .data_n_o (data_n),
    .valid_o  (valid)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d (cycle %0d)", tag, act, exp, cyc);
    end
  endtask

  task automatic finish_run();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  endtask

  // monitor: one compare per rising edge of the recovered clock
  logic r_p1 = 1'b1, r_p2 = 1'b1, d_p1 = 1'b0;
  int   low_cnt = 0;
  always @(negedge clk) begin
    if (rst_ni) begin
      if (data_n != d_p1)
        chk(r_p1 == 1'b0 && r_p2 == 1'b1, "R6 data change not right after clock fall",
            {30'd0, r_p2, r_p1}, 2);
      if (rclk && !r_p1 && valid) begin
        if (exp_idx >= burst_len) begin
          chk(1'b0, "R3 extra recovered clock edge", exp_idx, burst_len - 1);
        end else begin
          chk(!data_n == exp_bits[exp_idx],
              (exp_idx == 0) ? "R2 first bit of burst" : "R1 decoded bit",
              int'(!data_n), int'(exp_bits[exp_idx]));
          if (exp_idx < burst_len - 1 && exp_bits[exp_idx+1] == exp_bits[exp_idx])
            chk(low_cnt == bnd_n[exp_idx] - mid_n[exp_idx], "R5 pass-through low time",
                low_cnt, bnd_n[exp_idx] - mid_n[exp_idx]);
          else
            chk(low_cnt == HALF, "R4 fixed half-cell low time", low_cnt, HALF);
          exp_idx++;
        end
      end
      low_cnt = rclk ? 0 : low_cnt + 1;
    end
    r_p2 = r_p1;
    r_p1 = rclk;
    d_p1 = data_n;
  end

  task automatic wait_until(input int target);
    while (cyc < target) @(negedge clk);
  endtask

  // mode: 0 random, 1 alternating, 2 constant
  task automatic drive_burst(input int len, input int mode, input real scale, input real duty,
                             input string name);
    real t_cell;
    int  ncyc;
    int  last;
    t_cell = real'(OVS) * scale;
    exp_bits[0] = line;
    for (int i = 1; i < len; i++) begin
      case (mode)
        1:       exp_bits[i] = ~exp_bits[i-1];
        2:       exp_bits[i] = exp_bits[0];
        default: exp_bits[i] = 1'($urandom);
      endcase
    end
    exp_idx = 0;
    burst_len = len;
    ncyc = int'($ceil(real'(len) * t_cell));
    for (int n = 0; n < ncyc; n++) begin
      int   k;
      real  pos;
      logic lv;
      k = int'($floor(real'(n) / t_cell));
      if (k >= len) k = len - 1;
      pos = real'(n) - real'(k) * t_cell;
      lv = (pos < duty * t_cell) ? exp_bits[k] : ~exp_bits[k];
      @(negedge clk);
      if (lv != line) begin
        if (pos < duty * t_cell) bnd_n[k-1] = cyc;
        else                     mid_n[k]   = cyc;
      end
      line = lv;
    end
    last = mid_n[len-1];
    // R8: still valid shortly before the timeout, dropped after it
    wait_until(last + IDLE - 4);
    chk(valid == 1'b1, {"R8 valid before timeout ", name}, valid, 1);
    wait_until(last + IDLE + 10);
    chk(valid == 1'b0, {"R8 valid after timeout ", name}, valid, 0);
    chk(rclk == 1'b1, {"R8 clock high when idle ", name}, rclk, 1);
    chk(exp_idx == len, {"R3 one clock per bit ", name}, exp_idx, len);
  endtask

  task automatic t_reset();
    repeat (3) @(negedge clk);
    chk(rclk == 1'b1 && data_n == 1'b0 && valid == 1'b0, "R9 outputs in reset",
        {29'd0, rclk, data_n, valid}, 4);
    rst_ni = 1'b1;
    repeat (10) @(negedge clk);
    chk(rclk == 1'b1 && data_n == 1'b0 && valid == 1'b0, "R9 outputs after reset",
        {29'd0, rclk, data_n, valid}, 4);
  endtask

  task automatic t_nominal();    drive_burst(24, 0, 1.00, 0.500, "nominal");     endtask
  task automatic t_alternate();  drive_burst(16, 1, 1.00, 0.500, "alternating"); endtask
  task automatic t_constant();   drive_burst(16, 2, 1.00, 0.500, "constant");    endtask
  task automatic t_fast_long();  drive_burst(32, 0, 0.85, 0.575, "R7 fast long first half");  endtask
  task automatic t_fast_short(); drive_burst(32, 0, 0.85, 0.425, "R7 fast short first half"); endtask
  task automatic t_slow_short(); drive_burst(32, 0, 1.15, 0.425, "R7 slow short first half"); endtask
  task automatic t_slow_long();  drive_burst(32, 0, 1.15, 0.575, "R7 slow long first half");  endtask
  task automatic t_slow_const(); drive_burst(20, 2, 1.15, 0.425, "R7 slow constant");  endtask
  task automatic t_single();     drive_burst(1, 0, 1.00, 0.500, "R2 single bit");     endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_cmp++;
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      finish_run();
    end
  end

  initial begin
    t_reset();
    t_nominal();
    t_alternate();
    t_constant();
    t_fast_long();
    t_fast_short();
    t_slow_short();
    t_slow_long();
    t_slow_const();
    t_single();
    for (int i = 0; i < 6; i++) t_nominal();
    done = 1;
    finish_run();
  end
endmodule